// File: doc/BRIEF.md
# Symmetric PWM Timer with Bottom-Loaded Compare Registers

This block is a 16-bit up/down counter that drives two pulse-width-modulated outputs, channel A and channel B. The waveform is centre-aligned: the count climbs from zero to a top value, holds there for one enabled tick, falls back to zero, holds there for one enabled tick, and climbs again. Each channel compares the count against its own compare value. A match changes that channel's output one way while the count rises and the other way while it falls, so the pulse is always centred on the top of the count.

The period comes from one of two registers, picked by a select input. The first is a dedicated period register. The second is channel A's compare register. Software writes go to shadow copies of the period register and both compare registers. The active copies take the shadow values only at the bottom of the count. Because of this, every period is symmetric, even when its length or duty is changed while the counter runs. Four sticky event flags record bottom, top and compare-match events. A flag is cleared by writing 1 to its bit. The counter moves only on cycles where the tick input is high, so an external prescaler sets the rate.

Top module: `dspwm_timer`

## Requirements
- R1: On each cycle with `tick` high, `cnt` follows the sequence 0,1,…,T,T-1,…,1,0,1,… where T is the effective top. The values T and 0 each last exactly one tick. With `tick` low, `cnt` holds.
- R2: With `top_src`=0, the top is the active period register. With `top_src`=1, the top is the active compare A register. Any top value below 3 is treated as 3.
- R3: A write with `wr_en`=1 stores `wr_data` in a shadow register chosen by `wr_sel`: 0 selects the period register, 1 selects compare A, 2 selects compare B, and 3 selects nothing. All three active registers copy their shadows on a tick where `cnt` is 0, using the shadow values from before any write in that same cycle.
- R4: `flags[3]` is set on every tick where `cnt` is 0.
- R5: `flags[0]` is set on a tick where `cnt` equals active compare A. `flags[1]` is set on a tick where `cnt` equals active compare B. Both comparisons use the active values held before that tick.
- R6: On the tick where the count turns at top, `flags[2]` is set if `top_src`=0, and `flags[0]` is set if `top_src`=1.
- R7: Each bit of `flags` is cleared when the same bit of `flag_clr` is 1 in that cycle. A flag set in that same cycle stays set.
- R8: An output mode whose bit 1 is 0 drives the channel output low from the next cycle. In mode 2, a match tick while rising drives the output low, and a match tick while falling drives it high. Mode 3 does the opposite. The top tick counts as rising. The bottom tick counts as falling only when the count has come down to it.
- R9: After a synchronous reset, `cnt` is 0 and rising, both outputs are low, and all flags and all shadow and active registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 compare A, 2 compare B, 3 none |
| wr_data | input | 16 | Write data |
| top_src | input | 1 | Top source: 0 period register, 1 compare A |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| cnt | output | 16 | Current count |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| flags | output | 4 | Sticky flags: bit0 match A, bit1 match B, bit2 top by period register, bit3 bottom |

## Verification
The assertions rely on three things. Reset is applied from time zero. The tick input is a plain level sampled at each clock. The output-mode inputs change only between clock edges. The stepping property also relies on the count never wrapping. This holds because every legal top lies between 3 and the counter's full range, and the stimulus keeps it so. Random traffic writes period and compare values in the range 0 to about 45. This range includes values below the clamp and compare values beyond the top. It also toggles the tick density, the top source and the output modes at random, so that mode changes mid-period are covered. Short periods keep many bottom reloads within the run.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
  // write targets for the shadow registers
  typedef enum logic [1:0] {
    TGT_PERIOD = 2'd0,
    TGT_CMPA   = 2'd1,
    TGT_CMPB   = 2'd2,
    TGT_NONE   = 2'd3
  } wr_tgt_e;

  localparam int NUM_REGS   = 3;
  localparam int NUM_CH     = 2;
  localparam int NUM_FLAGS  = 4;
  localparam int FLG_MATCHA = 0;
  localparam int FLG_MATCHB = 1;
  localparam int FLG_TOP    = 2;
  localparam int FLG_BOTTOM = 3;
endpackage

// File: rtl/dspwm_regs.sv
module dspwm_regs
  import dspwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_sel,
  input  logic [WIDTH-1:0]               wr_data,
  input  logic                           load,
  output logic [NUM_REGS-1:0][WIDTH-1:0] act_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] active_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en && (wr_sel == 2'(i)))
          shadow_q <= wr_data;
        // reload takes the shadow value from before this cycle's write
        if (load)
          active_q <= shadow_q;
      end
    end

    assign act_o[i] = active_q;
  end
endmodule

// File: rtl/dspwm_counter.sv
module dspwm_counter #(
  parameter int WIDTH   = 16,
  parameter int MIN_TOP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [WIDTH-1:0] top_raw,
  output logic [WIDTH-1:0] cnt,
  output logic             rising,
  output logic             at_bottom,
  output logic             at_top
);
  localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN_TOP);
  localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic             up_q;
  logic [WIDTH-1:0] eff_top;

  assign eff_top   = (top_raw < MIN_V) ? MIN_V : top_raw;
  assign at_bottom = tick && (cnt_q == '0);
  assign at_top    = tick && up_q && (cnt_q != '0) && (cnt_q >= eff_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q <= ONE;
        up_q  <= 1'b1;
      end else if (up_q && (cnt_q >= eff_top)) begin
        cnt_q <= cnt_q - ONE;
        up_q  <= 1'b0;
      end else if (up_q) begin
        cnt_q <= cnt_q + ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt    = cnt_q;
  assign rising = up_q;
endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp,
  input  logic             rising,
  output logic             match,
  output logic             pwm
);
  logic pwm_q;

  assign match = (cnt == cmp);

  // mode[1]=0: output parked low; mode[0] picks the polarity
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else if (!mode[1]) begin
      pwm_q <= 1'b0;
    end else if (tick && match) begin
      pwm_q <= mode[0] ? rising : !rising;
    end
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
  import dspwm_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MIN_TOP = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic                 top_src,
  input  logic [1:0]           out_mode_a,
  input  logic [1:0]           out_mode_b,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [WIDTH-1:0]     cnt,
  output logic                 pwm_a,
  output logic                 pwm_b,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int IDX_PERIOD = int'(TGT_PERIOD);
  localparam int IDX_CMPA   = int'(TGT_CMPA);

  logic [NUM_REGS-1:0][WIDTH-1:0] act;
  logic [WIDTH-1:0]               top_raw;
  logic                           rising;
  logic                           at_bottom;
  logic                           at_top;
  logic [NUM_CH-1:0]              ch_match;
  logic [NUM_CH-1:0]              ch_pwm;
  logic [NUM_CH-1:0][1:0]         ch_mode;
  logic [NUM_FLAGS-1:0]           flag_set;
  logic [NUM_FLAGS-1:0]           flags_q;

  dspwm_regs #(.WIDTH(WIDTH)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .load    (at_bottom),
    .act_o   (act)
  );

  assign top_raw = top_src ? act[IDX_CMPA] : act[IDX_PERIOD];

  dspwm_counter #(.WIDTH(WIDTH), .MIN_TOP(MIN_TOP)) counter_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .top_raw   (top_raw),
    .cnt       (cnt),
    .rising    (rising),
    .at_bottom (at_bottom),
    .at_top    (at_top)
  );

  assign ch_mode[0] = out_mode_a;
  assign ch_mode[1] = out_mode_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dspwm_channel #(.WIDTH(WIDTH)) chan_i (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .mode   (ch_mode[c]),
      .cnt    (cnt),
      .cmp    (act[c+1]),
      .rising (rising),
      .match  (ch_match[c]),
      .pwm    (ch_pwm[c])
    );
  end

  assign pwm_a = ch_pwm[0];
  assign pwm_b = ch_pwm[1];

  always_comb begin
    flag_set             = '0;
    flag_set[FLG_MATCHA] = (tick && ch_match[0]) || (at_top && top_src);
    flag_set[FLG_MATCHB] = tick && ch_match[1];
    flag_set[FLG_TOP]    = at_top && !top_src;
    flag_set[FLG_BOTTOM] = at_bottom;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign flags = flags_q;
endmodule

// File: rtl/dspwm_checker.sv
module dspwm_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [WIDTH-1:0] cnt,
  input logic             bottom_flag,
  input logic             mode_a_on,
  input logic             mode_b_on,
  input logic             pwm_a,
  input logic             pwm_b
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1: an enabled tick moves the count by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !rst) |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

  // R1: no tick, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rst) |=> $stable(cnt));

  // R4: bottom tick raises the bottom flag and leaves zero upward
  a_r4_bottom: assert property (@(posedge clk) disable iff (rst)
    (tick && !rst && cnt == '0) |=> (bottom_flag && cnt == ONE));

  // R8: parked modes drive low
  a_r8_off_a: assert property (@(posedge clk) disable iff (rst)
    (!rst && !mode_a_on) |=> !pwm_a);

  a_r8_off_b: assert property (@(posedge clk) disable iff (rst)
    (!rst && !mode_b_on) |=> !pwm_b);

  // R8: outputs only move on enabled ticks while active
  a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
    (!rst && !tick && mode_a_on) |=> $stable(pwm_a));
endmodule

bind dspwm_timer dspwm_checker #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .cnt         (cnt),
  .bottom_flag (flags[3]),
  .mode_a_on   (out_mode_a[1]),
  .mode_b_on   (out_mode_b[1]),
  .pwm_a       (pwm_a),
  .pwm_b       (pwm_b)
);

// File: tb/dspwm_timer_tb.sv
`timescale 1ns/1ps
module dspwm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        top_src = 1'b0;
  logic [1:0]  out_mode_a = 2'd0;
  logic [1:0]  out_mode_b = 2'd0;
  logic [3:0]  flag_clr = 4'd0;
  logic [15:0] cnt;
  logic        pwm_a, pwm_b;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dspwm_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .top_src(top_src), .out_mode_a(out_mode_a),
    .out_mode_b(out_mode_b), .flag_clr(flag_clr), .cnt(cnt),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
  );

  // reference model state
  logic [15:0] m_cnt;
  bit          m_up;
  logic [15:0] m_buf [3];
  logic [15:0] m_act [3];
  logic [3:0]  m_flags;
  bit          m_pwm [2];

  function automatic logic [15:0] eff_top(input logic [15:0] raw);
    return (raw < 16'd3) ? 16'd3 : raw;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_flags = 0;
    for (int i = 0; i < 3; i++) begin m_buf[i] = 0; m_act[i] = 0; end
    m_pwm[0] = 0; m_pwm[1] = 0;
  endtask

  task automatic model_step();
    logic [15:0] et;
    logic [3:0]  set;
    logic [1:0]  md;
    bit bot, tp;
    if (rst) begin model_reset(); return; end
    et  = eff_top(top_src ? m_act[1] : m_act[0]);
    bot = tick && (m_cnt == 0);
    tp  = tick && m_up && (m_cnt != 0) && (m_cnt >= et);
    set = 0;
    if (tick && m_cnt == m_act[1]) set[0] = 1;
    if (tick && m_cnt == m_act[2]) set[1] = 1;
    if (tp && top_src)  set[0] = 1;
    if (tp && !top_src) set[2] = 1;
    if (bot) set[3] = 1;
    for (int c = 0; c < 2; c++) begin
      md = (c == 0) ? out_mode_a : out_mode_b;
      if (!md[1]) m_pwm[c] = 0;
      else if (tick && m_cnt == m_act[c+1]) m_pwm[c] = md[0] ? m_up : !m_up;
    end
    m_flags = (m_flags & ~flag_clr) | set;
    if (bot) for (int i = 0; i < 3; i++) m_act[i] = m_buf[i];
    if (wr_en && wr_sel != 2'd3) m_buf[wr_sel] = wr_data;
    if (tick) begin
      if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
      else if (m_up && m_cnt >= et) begin m_cnt = m_cnt - 1; m_up = 0; end
      else if (m_up) m_cnt = m_cnt + 1;
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actv, expv);
    end
  endtask

  task automatic compare_all();
    chk(cnt == m_cnt, "R1", "cnt", cnt, m_cnt);
    chk(pwm_a == m_pwm[0], "R8", "pwm_a", pwm_a, m_pwm[0]);
    chk(pwm_b == m_pwm[1], "R8", "pwm_b", pwm_b, m_pwm[1]);
    chk(flags[0] == m_flags[0], "R5", "flag matchA", flags[0], m_flags[0]);
    chk(flags[1] == m_flags[1], "R5", "flag matchB", flags[1], m_flags[1]);
    chk(flags[2] == m_flags[2], "R6", "flag top", flags[2], m_flags[2]);
    chk(flags[3] == m_flags[3], "R4", "flag bottom", flags[3], m_flags[3]);
  endtask

  // one clock: inputs already set, model steps at the edge, compare mid-cycle
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; flag_clr = 0;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc();
  endtask

  task automatic run_peak(input int n, output int peak);
    peak = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (int'(cnt) > peak) peak = int'(cnt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int peak;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) cyc();
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk(cnt == 0, "R9", "cnt after reset", cnt, 0);
    chk(flags == 0, "R9", "flags after reset", flags, 0);
    chk(pwm_a == 0 && pwm_b == 0, "R9", "pwm after reset", {pwm_a, pwm_b}, 0);

    // R2 clamp: zero buffers give top 3
    tick = 1;
    run_peak(14, peak);
    chk(peak == 3, "R2", "clamped top from reset", peak, 3);

    // directed: period 5, compares 2 and 4, A non-inverted, B inverted
    write_reg(2'd0, 16'd5);
    write_reg(2'd1, 16'd2);
    write_reg(2'd2, 16'd4);
    out_mode_a = 2'd2; out_mode_b = 2'd3;
    repeat (30) cyc();

    // R3: a period write mid-rise takes effect only after the next bottom
    while (!(m_cnt == 2 && m_up)) cyc();
    write_reg(2'd0, 16'd9);
    repeat (5) cyc();
    chk(cnt == 2, "R3", "old top kept until bottom", cnt, 2);
    while (m_cnt != 0) cyc();
    run_peak(14, peak);
    chk(peak == 9, "R3", "new top after bottom", peak, 9);

    // R3: target 3 writes nothing
    write_reg(2'd3, 16'd1);
    repeat (40) cyc();

    // R2: compare A as top
    write_reg(2'd1, 16'd6);
    top_src = 1;
    repeat (40) cyc();
    run_peak(14, peak);
    chk(peak == 6, "R2", "top from compare A", peak, 6);
    chk(flags[2] == 0 || m_flags[2] == 1, "R6", "top flag source", flags[2], m_flags[2]);

    // R2: period register below 3 clamps
    top_src = 0;
    write_reg(2'd0, 16'd1);
    repeat (40) cyc();
    run_peak(10, peak);
    chk(peak == 3, "R2", "period 1 clamped", peak, 3);

    // R7: write-one-to-clear with no tick
    tick = 0; flag_clr = 4'hF;
    cyc();
    chk(flags == 0, "R7", "flags cleared", flags, 0);
    // R7: set wins over clear on a bottom tick
    tick = 1;
    while (m_cnt != 0) cyc();
    flag_clr = 4'h8;
    cyc();
    chk(flags[3] == 1, "R7", "set beats clear", flags[3], 1);

    // R8: parking a channel drives it low
    out_mode_a = 2'd1;
    cyc();
    chk(pwm_a == 0, "R8", "parked channel low", pwm_a, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 12 == 0) begin
        wr_en = 1; wr_sel = 2'($urandom % 4);
        wr_data = 16'($urandom % 46);
      end
      if ($urandom % 150 == 0) top_src = ~top_src;
      if ($urandom % 100 == 0) out_mode_a = 2'($urandom % 4);
      if ($urandom % 100 == 0) out_mode_b = 2'($urandom % 4);
      if ($urandom % 20 == 0) flag_clr = 4'($urandom % 16);
      cyc();
    end

    // R9: reset mid-run
    rst = 1;
    cyc();
    rst = 0;
    chk(cnt == 0 && flags == 0, "R9", "mid-run reset", {cnt, flags}, 0);
    repeat (20) cyc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule